// File: doc/BRIEF.md
# Stop-Mode Power Controller

This block decides when a small microcontroller enters its deepest low-power state and how it comes back out. Software must first unlock entry by writing two bytes in a row to a key register. The first byte must have the upper nibble 5h, and the second must have the upper nibble Ah. After that, software sets the request bit in the standby register. While stopped, both oscillator enables and every clock gate are off.

A non-maskable interrupt or an enabled port interrupt wakes the block. The low-speed oscillator restarts at once. The high-speed oscillator restarts only if it was enabled at the moment of entry. The clock gates stay closed until the low-speed oscillator reports that it is ready and a settling count of low-speed clock cycles has then elapsed.

The block is clocked by the low-speed clock. A two-bit mode output shows whether the block is in run, stop or wake-up.

Top module: `stopctl_top`

## Requirements
- R1: The key register is written with regWrEn=1 and regAddr=0. The block becomes armed only when a key write with upper nibble 5h is followed, as the very next key write, by a key write with upper nibble Ah. The low nibbles of both bytes are ignored. While armed, a standby write (regWrEn=1, regAddr=1) with regWrData bit 0 set to 1 moves the mode from run (modeOut=2'b00) to stop (modeOut=2'b01) on the next cycle.
- R2: A standby write with bit 0 set to 1 while the block is not armed has no effect: the mode stays run and stopBit stays 0. A standby write with bit 0 set to 0 leaves the armed state as it is.
- R3: Any key write that breaks the sequence disarms the block. This covers an upper nibble other than Ah after a 5h, and any key write made while armed. A 5h key write always restarts the sequence at its first step.
- R4: Entering stop disarms the block, so each later entry needs a fresh two-byte unlock.
- R5: In stop, lsOscEn, hsOscEn, sysClkEn, perLsClkEn and perHsClkEn are all 0, and stopBit is 1.
- R6: In stop, nmiReq, or any portIrq bit whose portIrqEn bit is 1, moves the mode to wake-up (modeOut=2'b10) on the next cycle and clears stopBit. A port request with its enable at 0 leaves the block in stop.
- R7: During wake-up, lsOscEn is 1 and hsOscEn equals the value hsEnReq had on the cycle of entry. Changes to hsEnReq made while stopped do not affect it.
- R8: During wake-up all clock gates stay closed. The mode returns to run on the (SETTLE_CNT+1)-th rising edge, counted from the first edge that samples lsReady high. From then on sysClkEn and perLsClkEn are 1, and perHsClkEn is 1 when the high-speed oscillator was restarted.
- R9: In run, lsOscEn, sysClkEn and perLsClkEn are 1, and both hsOscEn and perHsClkEn follow hsEnReq. Interrupt requests have no effect on the mode in run.
- R10: After reset the mode is run, the block is disarmed and stopBit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 selects the key register, 1 selects the standby register |
| regWrData | input | DW | Write data |
| nmiReq | input | 1 | Non-maskable interrupt request |
| portIrq | input | NPORT | Port pin interrupt requests |
| portIrqEn | input | NPORT | Per-pin interrupt enable flags |
| hsEnReq | input | 1 | Software request for the high-speed oscillator |
| lsReady | input | 1 | Low-speed oscillator has started |
| modeOut | output | 2 | 00 run, 01 stop, 10 wake-up |
| stopBit | output | 1 | Read-back of the stop request bit |
| lsOscEn | output | 1 | Low-speed oscillator enable |
| hsOscEn | output | 1 | High-speed oscillator enable |
| sysClkEn | output | 1 | CPU clock gate enable |
| perLsClkEn | output | 1 | Peripheral low-speed clock gate enable |
| perHsClkEn | output | 1 | Peripheral high-speed clock gate enable |

## Verification
The hardest state to reach is the armed state after an unusual key history. Examples are a repeated 5h, a trailing extra byte, or a standby write with the request bit clear placed between the unlock and the real request. Each of these decides only whether the next request enters stop. The bench walks every pair of upper nibbles with varied low nibbles, clearing the sequence with a 00h key write before each pair, and adds short directed histories. Every wake source is then swept with its enable set and cleared, and with the high-speed request flipped while stopped. This shows that the enable captured at entry, not the live one, drives the restart.

// File: rtl/stopctl_pkg.sv
package stopctl_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_STOP = 2'b01,
    MODE_WAKE = 2'b10
  } mode_e;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'b00,
    UL_FIRST = 2'b01,
    UL_ARMED = 2'b10
  } unlock_e;

  typedef struct packed {
    logic cntClear;
    logic cntStep;
    logic hsCapture;
  } dpStrobe_t;

  localparam logic [3:0] KEY_FIRST  = 4'h5;
  localparam logic [3:0] KEY_SECOND = 4'hA;

endpackage

// File: rtl/stopctl_dp.sv
module stopctl_dp
  import stopctl_pkg::*;
#(
  parameter int SETTLE_CNT = 8192,
  parameter int NPORT      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [3:0]       keyNibble,
  input  logic             hsEnReq,
  input  logic             nmiReq,
  input  logic [NPORT-1:0] portIrq,
  input  logic [NPORT-1:0] portIrqEn,
  output logic             keyFirst,
  output logic             keySecond,
  output logic             wakeReq,
  output logic             settleDone,
  output logic             hsSaved
);

  localparam int CW = (SETTLE_CNT > 1) ? $clog2(SETTLE_CNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CNT - 1);

  logic [CW-1:0]    settleCnt;
  logic [NPORT-1:0] pinWake;

  assign keyFirst  = (keyNibble == KEY_FIRST);
  assign keySecond = (keyNibble == KEY_SECOND);

  for (genvar i = 0; i < NPORT; i++) begin : g_pin
    assign pinWake[i] = portIrq[i] & portIrqEn[i];
  end

  assign wakeReq    = nmiReq | (|pinWake);
  assign settleDone = (settleCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
    end else if (strobe.cntClear) begin
      settleCnt <= '0;
    end else if (strobe.cntStep) begin
      settleCnt <= settleCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsSaved <= 1'b0;
    end else if (strobe.hsCapture) begin
      hsSaved <= hsEnReq;
    end
  end

endmodule

// File: rtl/stopctl_ctrl.sv
module stopctl_ctrl
  import stopctl_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      regWrEn,
  input  logic      regAddr,
  input  logic      stopReqBit,
  input  logic      keyFirst,
  input  logic      keySecond,
  input  logic      wakeReq,
  input  logic      lsReady,
  input  logic      settleDone,
  output mode_e     mode,
  output dpStrobe_t strobe
);

  unlock_e ulState, ulNext;
  mode_e   modeNext;
  logic    settling, settlingNext;
  logic    codeWr, sbyWr, enterStop;

  assign codeWr    = regWrEn && !regAddr;
  assign sbyWr     = regWrEn && regAddr;
  assign enterStop = (mode == MODE_RUN) && sbyWr && stopReqBit && (ulState == UL_ARMED);

  always_comb begin
    ulNext = ulState;
    if (enterStop) begin
      ulNext = UL_IDLE;
    end else if (codeWr) begin
      unique case (ulState)
        UL_FIRST: ulNext = keySecond ? UL_ARMED : (keyFirst ? UL_FIRST : UL_IDLE);
        default:  ulNext = keyFirst ? UL_FIRST : UL_IDLE;
      endcase
    end
  end

  always_comb begin
    modeNext     = mode;
    settlingNext = settling;
    strobe       = '0;
    unique case (mode)
      MODE_RUN: begin
        if (enterStop) begin
          modeNext         = MODE_STOP;
          strobe.hsCapture = 1'b1;
        end
      end
      MODE_STOP: begin
        if (wakeReq) begin
          modeNext     = MODE_WAKE;
          settlingNext = 1'b0;
        end
      end
      default: begin
        if (!settling) begin
          if (lsReady) begin
            settlingNext    = 1'b1;
            strobe.cntClear = 1'b1;
          end
        end else if (settleDone) begin
          modeNext     = MODE_RUN;
          settlingNext = 1'b0;
        end else begin
          strobe.cntStep = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ulState  <= UL_IDLE;
      mode     <= MODE_RUN;
      settling <= 1'b0;
    end else begin
      ulState  <= ulNext;
      mode     <= modeNext;
      settling <= settlingNext;
    end
  end

endmodule

// File: rtl/stopctl_top.sv
module stopctl_top
  import stopctl_pkg::*;
#(
  parameter int SETTLE_CNT = 8192,
  parameter int NPORT      = 8,
  parameter int DW         = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regAddr,
  input  logic [DW-1:0]    regWrData,
  input  logic             nmiReq,
  input  logic [NPORT-1:0] portIrq,
  input  logic [NPORT-1:0] portIrqEn,
  input  logic             hsEnReq,
  input  logic             lsReady,
  output logic [1:0]       modeOut,
  output logic             stopBit,
  output logic             lsOscEn,
  output logic             hsOscEn,
  output logic             sysClkEn,
  output logic             perLsClkEn,
  output logic             perHsClkEn
);

  mode_e     mode;
  dpStrobe_t strobe;
  logic      keyFirst, keySecond, wakeReq, settleDone, hsSaved;
  logic      unusedDataBits;

  assign unusedDataBits = ^regWrData[DW-5:1];

  stopctl_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .stopReqBit (regWrData[0]),
    .keyFirst   (keyFirst),
    .keySecond  (keySecond),
    .wakeReq    (wakeReq),
    .lsReady    (lsReady),
    .settleDone (settleDone),
    .mode       (mode),
    .strobe     (strobe)
  );

  stopctl_dp #(.SETTLE_CNT(SETTLE_CNT), .NPORT(NPORT)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .keyNibble  (regWrData[DW-1:DW-4]),
    .hsEnReq    (hsEnReq),
    .nmiReq     (nmiReq),
    .portIrq    (portIrq),
    .portIrqEn  (portIrqEn),
    .keyFirst   (keyFirst),
    .keySecond  (keySecond),
    .wakeReq    (wakeReq),
    .settleDone (settleDone),
    .hsSaved    (hsSaved)
  );

  assign modeOut    = mode;
  assign stopBit    = (mode == MODE_STOP);
  assign lsOscEn    = (mode != MODE_STOP);
  assign hsOscEn    = (mode == MODE_RUN) ? hsEnReq : ((mode == MODE_WAKE) && hsSaved);
  assign sysClkEn   = (mode == MODE_RUN);
  assign perLsClkEn = (mode == MODE_RUN);
  assign perHsClkEn = (mode == MODE_RUN) && hsEnReq;

endmodule

// File: rtl/stopctl_chk.sv
module stopctl_chk #(
  parameter int SETTLE_CNT = 8192,
  parameter int NPORT      = 8,
  parameter int DW         = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic             regAddr,
  input logic [DW-1:0]    regWrData,
  input logic             nmiReq,
  input logic [NPORT-1:0] portIrq,
  input logic [NPORT-1:0] portIrqEn,
  input logic             hsEnReq,
  input logic             lsReady,
  input logic [1:0]       modeOut,
  input logic             stopBit,
  input logic             lsOscEn,
  input logic             hsOscEn,
  input logic             sysClkEn,
  input logic             perLsClkEn,
  input logic             perHsClkEn,
  input logic             hsSaved
);

  int   ckCnt;
  logic ckReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ckCnt   <= 0;
      ckReady <= 1'b0;
    end else if (modeOut != 2'b10) begin
      ckCnt   <= 0;
      ckReady <= 1'b0;
    end else if (ckReady) begin
      ckCnt <= ckCnt + 1;
    end else if (lsReady) begin
      ckReady <= 1'b1;
    end
  end

  // R1 / R2: stop is entered only through a standby write with bit 0 set
  a_r1_entry_by_write: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'b01 && $past(modeOut) == 2'b00) |-> $past(regWrEn && regAddr && regWrData[0]));

  // R5: oscillators and gates off while stopped
  a_r5_stop_all_off: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'b01) |-> (!lsOscEn && !hsOscEn && !sysClkEn && !perLsClkEn && !perHsClkEn && stopBit));

  // R6: leaving stop needs a qualified wake request
  a_r6_wake_source: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'b10 && $past(modeOut) == 2'b01) |-> $past(nmiReq || ((portIrq & portIrqEn) != '0)));

  // R7: low-speed on, high-speed as captured at entry
  a_r7_wake_osc: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'b10) |-> (lsOscEn && (hsOscEn == hsSaved)));

  // R8: gates closed during wake-up
  a_r8_gates_closed: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'b10) |-> (!sysClkEn && !perLsClkEn && !perHsClkEn));

  // R8: settling length measured by a counter
  a_r8_settle_len: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'b00 && $past(modeOut) == 2'b10) |-> (ckCnt == SETTLE_CNT));

  // R9: interrupts ignored in run
  a_r9_run_holds: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeOut) == 2'b00 && !$past(regWrEn)) |-> (modeOut == 2'b00));

endmodule

bind stopctl_top stopctl_chk #(.SETTLE_CNT(SETTLE_CNT), .NPORT(NPORT), .DW(DW)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .regWrEn    (regWrEn),
  .regAddr    (regAddr),
  .regWrData  (regWrData),
  .nmiReq     (nmiReq),
  .portIrq    (portIrq),
  .portIrqEn  (portIrqEn),
  .hsEnReq    (hsEnReq),
  .lsReady    (lsReady),
  .modeOut    (modeOut),
  .stopBit    (stopBit),
  .lsOscEn    (lsOscEn),
  .hsOscEn    (hsOscEn),
  .sysClkEn   (sysClkEn),
  .perLsClkEn (perLsClkEn),
  .perHsClkEn (perHsClkEn),
  .hsSaved    (hsSaved)
);

// File: tb/stopctl_tb.sv
module stopctl_top_tb_top;

  localparam int TB_SETTLE = 16;
  localparam int NPORT     = 8;
  localparam int DW        = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             regWrEn = 1'b0;
  logic             regAddr = 1'b0;
  logic [DW-1:0]    regWrData = '0;
  logic             nmiReq = 1'b0;
  logic [NPORT-1:0] portIrq = '0;
  logic [NPORT-1:0] portIrqEn = '0;
  logic             hsEnReq = 1'b0;
  logic             lsReady = 1'b0;
  logic [1:0]       modeOut;
  logic             stopBit, lsOscEn, hsOscEn, sysClkEn, perLsClkEn, perHsClkEn;

  int  nTests = 0;
  int  nFails = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  stopctl_top #(.SETTLE_CNT(TB_SETTLE), .NPORT(NPORT), .DW(DW)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .nmiReq(nmiReq), .portIrq(portIrq), .portIrqEn(portIrqEn), .hsEnReq(hsEnReq),
    .lsReady(lsReady), .modeOut(modeOut), .stopBit(stopBit), .lsOscEn(lsOscEn),
    .hsOscEn(hsOscEn), .sysClkEn(sysClkEn), .perLsClkEn(perLsClkEn), .perHsClkEn(perHsClkEn)
  );

  task automatic chk(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic unlock(input logic [3:0] lo1, input logic [3:0] lo2);
    wr(1'b0, 8'h00);
    wr(1'b0, {4'h5, lo1});
    wr(1'b0, {4'hA, lo2});
  endtask

  task automatic pulse(input logic nmi, input logic [NPORT-1:0] pins, input logic [NPORT-1:0] ens);
    @(negedge clk);
    nmiReq = nmi; portIrq = pins; portIrqEn = ens;
    @(posedge clk);
    @(negedge clk);
    nmiReq = 1'b0; portIrq = '0; portIrqEn = '0;
  endtask

  task automatic wakeAndSettle(input logic hsExp, input int delay);
    int k;
    chk("R7 lsOscEn in wake", int'(lsOscEn), 1);
    chk("R7 hsOscEn in wake", int'(hsOscEn), int'(hsExp));
    hsEnReq = hsExp;
    for (int d = 0; d < delay; d++) begin
      @(negedge clk);
      chk("R8 waits for lsReady", int'(modeOut), 2);
    end
    lsReady = 1'b1;
    k = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      k++;
      if (modeOut != 2'b00) chk("R8 gates closed", int'(sysClkEn | perLsClkEn | perHsClkEn), 0);
    end while (modeOut != 2'b00 && k < 4 * TB_SETTLE);
    lsReady = 1'b0;
    chk("R8 settle edges", k, TB_SETTLE + 1);
    chk("R8 sys clock back", int'(sysClkEn & perLsClkEn), 1);
    chk("R8 hs clock back", int'(perHsClkEn), int'(hsExp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 mode", int'(modeOut), 0);
    chk("R10 stopBit", int'(stopBit), 0);
    chk("R10 run gates", int'(lsOscEn & sysClkEn & perLsClkEn), 1);
    wr(1'b1, 8'h01);
    chk("R10 disarmed", int'(modeOut), 0);

    // R2 request while not armed
    wr(1'b0, 8'h00);
    wr(1'b1, 8'hFF);
    chk("R2 mode", int'(modeOut), 0);
    chk("R2 stopBit", int'(stopBit), 0);

    // R9 run-mode behaviour
    hsEnReq = 1'b1;
    @(negedge clk);
    chk("R9 hsOscEn follows", int'(hsOscEn & perHsClkEn), 1);
    pulse(1'b1, '1, '1);
    chk("R9 irq ignored", int'(modeOut), 0);
    hsEnReq = 1'b0;
    @(negedge clk);
    chk("R9 hsOscEn off", int'(hsOscEn | perHsClkEn), 0);

    // R1 / R3: sweep of all upper-nibble pairs
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        logic expEnter;
        expEnter = (a == 5) && (b == 10);
        wr(1'b0, 8'h00);
        wr(1'b0, 8'((a << 4) | ((a * 7 + b) & 15)));
        wr(1'b0, 8'((b << 4) | ((b * 3 + a) & 15)));
        wr(1'b1, 8'h01);
        chk("R1 R3 pair entry", int'(modeOut), expEnter ? 1 : 0);
        if (expEnter) begin
          pulse(1'b1, '0, '0);
          wakeAndSettle(1'b0, 0);
        end
      end
    end

    // R3 directed histories
    wr(1'b0, 8'h00); wr(1'b0, 8'h51); wr(1'b0, 8'hA2); wr(1'b0, 8'hA3); wr(1'b1, 8'h01);
    chk("R3 extra byte disarms", int'(modeOut), 0);
    wr(1'b0, 8'h00); wr(1'b0, 8'h5F); wr(1'b0, 8'hAF); wr(1'b0, 8'h50); wr(1'b1, 8'h01);
    chk("R3 5h restarts", int'(modeOut), 0);
    wr(1'b0, 8'h00); wr(1'b0, 8'h54); wr(1'b0, 8'h55); wr(1'b0, 8'hA6); wr(1'b1, 8'h01);
    chk("R3 repeated 5h arms", int'(modeOut), 1);
    pulse(1'b1, '0, '0);
    wakeAndSettle(1'b0, 1);

    // R2: standby write with bit 0 clear keeps armed state
    unlock(4'h0, 4'h0);
    wr(1'b1, 8'h00);
    chk("R2 bit0 clear no entry", int'(modeOut), 0);
    wr(1'b1, 8'h01);
    chk("R2 armed kept", int'(modeOut), 1);
    pulse(1'b1, '0, '0);
    wakeAndSettle(1'b0, 2);

    // R4 .. R8: wake-source sweep
    for (int hs = 0; hs < 2; hs++) begin
      for (int p = 0; p <= NPORT; p++) begin
        for (int en = 0; en < 2; en++) begin
          if (p == NPORT && en == 0) continue;
          hsEnReq = hs[0];
          unlock(4'(p), 4'(en));
          wr(1'b1, 8'h01);
          chk("R5 mode stop", int'(modeOut), 1);
          chk("R5 stopBit", int'(stopBit), 1);
          chk("R5 osc off", int'(lsOscEn | hsOscEn), 0);
          chk("R5 gates off", int'(sysClkEn | perLsClkEn | perHsClkEn), 0);
          hsEnReq = ~hs[0];
          if (p == NPORT) begin
            pulse(1'b1, '0, '0);
          end else begin
            pulse(1'b0, NPORT'(1) << p, en ? (NPORT'(1) << p) : ~(NPORT'(1) << p));
            if (en == 0) begin
              chk("R6 disabled pin ignored", int'(modeOut), 1);
              pulse(1'b1, '0, '0);
            end
          end
          chk("R6 wake mode", int'(modeOut), 2);
          chk("R6 stopBit cleared", int'(stopBit), 0);
          wakeAndSettle(hs[0], p);
          wr(1'b1, 8'h01);
          chk("R4 relock needed", int'(modeOut), 0);
        end
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule